// File: doc/BRIEF.md
# Dialed Bit-Field Transfer Unit

This unit performs a partial-word insert between two 48-bit operand registers, called A and B here. Each register has a "dial" that holds a start position. A transfer command then copies a run of bits out of A, beginning at A's dial, into B, beginning at B's dial. Both positions advance toward higher bit numbers, and every other bit of B keeps its value. Bit positions are counted from 0 at the most significant end. The unit moves one bit per clock. It raises `busy` while the copy runs and pulses `done` once the copy finishes. When a transfer completes, A is marked empty.

A dial command takes a 6-bit code. The upper three bits select a 6-bit character (0 to 7, counted from the left), and the lower three bits select a bit inside that character, so position = char*6 + bit. Codes whose bit part is 6 or 7 are refused. A transfer requested while A holds no operand is refused with an error. A copy that would run past bit 47 in either register stops at bit 47 and reports overflow.

The control follows a three-state machine. ST_IDLE accepts commands. The transitions IDLE->MOVE (an accepted transfer with a nonzero count) and IDLE->DONE (a zero count or an empty A) leave it. ST_MOVE copies one bit per cycle and takes MOVE->MOVE while bits remain. It takes MOVE->DONE on the last requested bit or when either position reaches 47. ST_DONE drives `done` for one cycle and always takes DONE->IDLE.

Top module: `bfx_unit`

## Requirements
- R1: After reset, A and B hold zero and both valid flags, `busy`, `done`, `err_dial`, `err_empty` and `overflow` are 0. Both dials hold position 0.
- R2: A dial code splits as char = code[5:3] and bit = code[2:0], and it selects position char*6+bit. Position p addresses word bit [47-p] (position 0 is the MSB). For example, code octal 43 selects position 27, which is word bit 20.
- R3: A dial code with bit part 6 or 7 sets `err_dial` in the next cycle and leaves that dial's position unchanged. An accepted dial code clears `err_dial`.
- R4: A transfer of n bits (1 to 63) from a valid A copies A position pa+i to B position pb+i for i = 0,1,... with one bit per clock. `busy` is high for the cycles of the copy, and `done` is high for exactly one cycle, k cycles after the request cycle, where k is the number of bits moved.
- R5: A transfer alters only the destination positions of B. All other bits of B are unchanged.
- R6: A transfer with count 0 from a valid A leaves B unchanged. It pulses `done` in the cycle after the request and clears `a_valid`.
- R7: `a_valid` goes to 0 exactly when a transfer from a valid A completes, which is the same cycle `done` is high.
- R8: A transfer requested while `a_valid` is 0 sets `err_empty` and pulses `done` in the next cycle, with B and `a_valid` unchanged. An accepted transfer from a valid A clears `err_empty`.
- R9: When either position reaches 47 before the count is used up, the transfer stops after writing that bit and sets `overflow`. A transfer that ends normally clears `overflow`.
- R10: While `busy` or `done` is high, every load, dial and transfer request is ignored.
- R11: In ST_IDLE, `a_load` and `b_load` write their data word and set the matching valid flag. A transfer request in the same cycle takes priority, and the loads and dials of that cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_load | input | 1 | Write `a_data` into A and mark A valid |
| a_data | input | 48 | Word for A |
| b_load | input | 1 | Write `b_data` into B and mark B valid |
| b_data | input | 48 | Word for B |
| dial_a_req | input | 1 | Set A's start position from `dial_a_code` |
| dial_a_code | input | 6 | Character (bits 5:3) and bit (bits 2:0) for A |
| dial_b_req | input | 1 | Set B's start position from `dial_b_code` |
| dial_b_code | input | 6 | Character (bits 5:3) and bit (bits 2:0) for B |
| xfer_req | input | 1 | Start a transfer |
| xfer_count | input | 6 | Number of bits to move |
| busy | output | 1 | Copy in progress (ST_MOVE) |
| done | output | 1 | One-cycle completion pulse (ST_DONE) |
| a_word | output | 48 | Contents of A |
| a_valid | output | 1 | A holds an operand |
| b_word | output | 48 | Contents of B |
| b_valid | output | 1 | B holds an operand |
| err_dial | output | 1 | Last dial command carried a bit part above 5 |
| err_empty | output | 1 | Last transfer was requested with A empty |
| overflow | output | 1 | Last transfer was cut short at position 47 |

## Verification
The copy is tried with a single isolated bit at a known dial, which distinguishes the MSB-first numbering and the char*6+bit decoding from a plain binary or LSB-first reading. It is also tried with a full 48-bit copy from position 0 to 0, which must reproduce A exactly, and with count 0, which must leave B alone. A batch of random words with random legal dials and counts checks that bits outside the field survive, and the overlapping source and destination offsets expose any off-by-one in either pointer. Runs placed so that either pointer hits bit 47 separate a correct early stop from a wrap or a missed flag. A request with A empty, refused dial codes, and commands poked during a busy copy confirm that the refused stimulus leaves A, the dials and B untouched.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MOVE = 2'd1,
        ST_DONE = 2'd2
    } bfx_state_t;

    localparam int DIAL_CODE_W = 6;
    localparam int DIAL_FIELD_W = 3;
endpackage

// File: rtl/bfx_dial_reg.sv
module bfx_dial_reg #(
    parameter int WORD_W    = 48,
    parameter int CHAR_BITS = 6,
    parameter int POS_W     = $clog2(WORD_W)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               load_en,
    input  logic [bfx_pkg::DIAL_CODE_W-1:0]    code,
    output logic [POS_W-1:0]                   pos,
    output logic                               code_bad
);
    import bfx_pkg::*;

    logic [DIAL_FIELD_W-1:0] char_sel;
    logic [DIAL_FIELD_W-1:0] bit_sel;
    logic [POS_W-1:0]        pos_new;

    assign char_sel = code[DIAL_CODE_W-1:DIAL_FIELD_W];
    assign bit_sel  = code[DIAL_FIELD_W-1:0];
    assign code_bad = (int'(bit_sel) >= CHAR_BITS);
    assign pos_new  = POS_W'(int'(char_sel) * CHAR_BITS + int'(bit_sel));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (load_en && !code_bad) begin
            pos <= pos_new;
        end
    end

    // R2
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pos) < WORD_W);

    // R3
    bad_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && code_bad) |=> $stable(pos));
endmodule

// File: rtl/bfx_bit_path.sv
module bfx_bit_path #(
    parameter int WORD_W = 48,
    parameter int POS_W  = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] a_word,
    input  logic [WORD_W-1:0] b_word,
    input  logic [POS_W-1:0]  src_pos,
    input  logic [POS_W-1:0]  dst_pos,
    output logic [WORD_W-1:0] b_next
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORD_W - 1);

    logic [POS_W-1:0] src_idx;
    logic [POS_W-1:0] dst_idx;

    assign src_idx = LAST_POS - src_pos;
    assign dst_idx = LAST_POS - dst_pos;

    always_comb begin
        b_next          = b_word;
        b_next[dst_idx] = a_word[src_idx];
    end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit #(
    parameter int WORD_W    = 48,
    parameter int CHAR_BITS = 6,
    parameter int CNT_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_load,
    input  logic [WORD_W-1:0] a_data,
    input  logic              b_load,
    input  logic [WORD_W-1:0] b_data,
    input  logic              dial_a_req,
    input  logic [5:0]        dial_a_code,
    input  logic              dial_b_req,
    input  logic [5:0]        dial_b_code,
    input  logic              xfer_req,
    input  logic [CNT_W-1:0]  xfer_count,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] a_word,
    output logic              a_valid,
    output logic [WORD_W-1:0] b_word,
    output logic              b_valid,
    output logic              err_dial,
    output logic              err_empty,
    output logic              overflow
);
    import bfx_pkg::*;

    localparam int               POS_W    = $clog2(WORD_W);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORD_W - 1);

    bfx_state_t        state, next_state;
    logic [CNT_W-1:0]  remain;
    logic [POS_W-1:0]  src_run, dst_run;
    logic [POS_W-1:0]  dial_a_pos, dial_b_pos;
    logic              dial_a_bad, dial_b_bad;
    logic              cmd_open, dial_a_en, dial_b_en;
    logic              last_step, edge_hit;
    logic [WORD_W-1:0] b_next;

    assign cmd_open  = (state == ST_IDLE) && !xfer_req;
    assign dial_a_en = cmd_open && dial_a_req;
    assign dial_b_en = cmd_open && dial_b_req;
    assign edge_hit  = (src_run == LAST_POS) || (dst_run == LAST_POS);
    assign last_step = (remain == CNT_W'(1)) || edge_hit;

    bfx_dial_reg #(.WORD_W(WORD_W), .CHAR_BITS(CHAR_BITS), .POS_W(POS_W)) u_dial_a (
        .clk(clk), .rst_n(rst_n), .load_en(dial_a_en), .code(dial_a_code),
        .pos(dial_a_pos), .code_bad(dial_a_bad)
    );

    bfx_dial_reg #(.WORD_W(WORD_W), .CHAR_BITS(CHAR_BITS), .POS_W(POS_W)) u_dial_b (
        .clk(clk), .rst_n(rst_n), .load_en(dial_b_en), .code(dial_b_code),
        .pos(dial_b_pos), .code_bad(dial_b_bad)
    );

    bfx_bit_path #(.WORD_W(WORD_W), .POS_W(POS_W)) u_path (
        .a_word(a_word), .b_word(b_word), .src_pos(src_run), .dst_pos(dst_run),
        .b_next(b_next)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next_state;
    end

    // transitions
    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE: if (xfer_req) begin
                if (!a_valid || xfer_count == '0) next_state = ST_DONE;
                else                               next_state = ST_MOVE;
            end
            ST_MOVE: if (last_step) next_state = ST_DONE;
            ST_DONE: next_state = ST_IDLE;
            default: next_state = ST_IDLE;
        endcase
    end

    assign busy = (state == ST_MOVE);
    assign done = (state == ST_DONE);

    // datapath and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_word    <= '0;
            b_word    <= '0;
            a_valid   <= 1'b0;
            b_valid   <= 1'b0;
            err_dial  <= 1'b0;
            err_empty <= 1'b0;
            overflow  <= 1'b0;
            remain    <= '0;
            src_run   <= '0;
            dst_run   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (xfer_req) begin
                        err_empty <= !a_valid;
                        overflow  <= 1'b0;
                        remain    <= xfer_count;
                        src_run   <= dial_a_pos;
                        dst_run   <= dial_b_pos;
                        if (a_valid && xfer_count == '0) a_valid <= 1'b0;
                    end else begin
                        if (a_load) begin
                            a_word  <= a_data;
                            a_valid <= 1'b1;
                        end
                        if (b_load) begin
                            b_word  <= b_data;
                            b_valid <= 1'b1;
                        end
                        if (dial_a_req || dial_b_req)
                            err_dial <= (dial_a_req && dial_a_bad) || (dial_b_req && dial_b_bad);
                    end
                end
                ST_MOVE: begin
                    b_word  <= b_next;
                    remain  <= remain - CNT_W'(1);
                    src_run <= src_run + POS_W'(1);
                    dst_run <= dst_run + POS_W'(1);
                    if (last_step) begin
                        a_valid  <= 1'b0;
                        overflow <= (remain != CNT_W'(1));
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // R4
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R5
    one_bit_per_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($countones(b_word ^ $past(b_word)) <= 1));

    // R7
    empty_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(a_valid) |-> done);

    // R8
    empty_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && xfer_req && !a_valid) |=> (err_empty && done && $stable(b_word)));

    // R9
    overflow_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> done);

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || done) |=> ($stable(a_word) && $stable(b_valid) && $stable(err_dial)));
endmodule

// File: tb/bfx_unit_tb.sv
`timescale 1ns/1ps
module bfx_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_load = 1'b0, b_load = 1'b0;
    logic [47:0] a_data = '0, b_data = '0;
    logic        dial_a_req = 1'b0, dial_b_req = 1'b0;
    logic [5:0]  dial_a_code = '0, dial_b_code = '0;
    logic        xfer_req = 1'b0;
    logic [5:0]  xfer_count = '0;
    logic        busy, done, a_valid, b_valid, err_dial, err_empty, overflow;
    logic [47:0] a_word, b_word;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        logic [47:0] b;
        logic        av;
        logic        ee;
        logic        ov;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    // reference model state
    logic [47:0] m_a = '0, m_b = '0;
    logic        m_av = 1'b0;
    int          m_pa = 0, m_pb = 0;

    always #5 clk = ~clk;

    bfx_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_load(a_load), .a_data(a_data), .b_load(b_load), .b_data(b_data),
        .dial_a_req(dial_a_req), .dial_a_code(dial_a_code),
        .dial_b_req(dial_b_req), .dial_b_code(dial_b_code),
        .xfer_req(xfer_req), .xfer_count(xfer_count),
        .busy(busy), .done(done), .a_word(a_word), .a_valid(a_valid),
        .b_word(b_word), .b_valid(b_valid), .err_dial(err_dial),
        .err_empty(err_empty), .overflow(overflow)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops scoreboard on each done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R4 unexpected done", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(b_word === e.b, {e.tag, " b_word"}, {16'd0, b_word}, {16'd0, e.b});
                check(a_valid === e.av, "R7 a_valid at done", {63'd0, a_valid}, {63'd0, e.av});
                check(err_empty === e.ee, "R8 err_empty", {63'd0, err_empty}, {63'd0, e.ee});
                check(overflow === e.ov, "R9 overflow", {63'd0, overflow}, {63'd0, e.ov});
            end
        end
    end

    task automatic load_a(input logic [47:0] w);
        @(negedge clk); a_load = 1'b1; a_data = w;
        @(negedge clk); a_load = 1'b0;
        m_a = w; m_av = 1'b1;
        check(a_word === w && a_valid === 1'b1, "R11 load A", {16'd0, a_word}, {16'd0, w});
    endtask

    task automatic load_b(input logic [47:0] w);
        @(negedge clk); b_load = 1'b1; b_data = w;
        @(negedge clk); b_load = 1'b0;
        m_b = w;
        check(b_word === w && b_valid === 1'b1, "R11 load B", {16'd0, b_word}, {16'd0, w});
    endtask

    task automatic dial(input bit which_b, input logic [5:0] code);
        bit bad;
        bad = (code[2:0] > 3'd5);
        @(negedge clk);
        if (which_b) begin dial_b_req = 1'b1; dial_b_code = code; end
        else         begin dial_a_req = 1'b1; dial_a_code = code; end
        @(negedge clk); dial_a_req = 1'b0; dial_b_req = 1'b0;
        check(err_dial === bad, "R3 err_dial", {63'd0, err_dial}, {63'd0, bad});
        if (!bad) begin
            if (which_b) m_pb = int'(code[5:3]) * 6 + int'(code[2:0]);
            else         m_pa = int'(code[5:3]) * 6 + int'(code[2:0]);
        end
    endtask

    task automatic xfer(input int n, input bit poke, input string tag);
        exp_t e;
        int moved;
        int j;
        moved = 0;
        e.ov = 1'b0;
        e.ee = !m_av;
        if (m_av) begin
            for (int i = 0; i < n; i++) begin
                if (m_pa + i > 47 || m_pb + i > 47) begin e.ov = 1'b1; break; end
                m_b[47 - (m_pb + i)] = m_a[47 - (m_pa + i)];
                moved++;
            end
            m_av = 1'b0;
        end
        e.b = m_b; e.av = m_av; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk); xfer_req = 1'b1; xfer_count = 6'(n);
        @(negedge clk); xfer_req = 1'b0;
        if (poke) begin
            a_load = 1'b1; a_data = 48'hFFFF_FFFF_FFFF;
            dial_a_req = 1'b1; dial_a_code = 6'o00;
            b_load = 1'b1; b_data = 48'h0;
        end
        j = 0;
        while (!done) begin
            @(negedge clk);
            a_load = 1'b0; dial_a_req = 1'b0; b_load = 1'b0;
            j++;
        end
        check(j == moved, "R4 cycles to done", 64'(j), 64'(moved));
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R4 back to idle", {62'd0, busy, done}, 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(a_word === '0 && b_word === '0 && !a_valid && !b_valid, "R1 words/valids",
              {a_valid, b_valid, 14'd0, a_word}, 64'd0);
        check(!busy && !done && !err_dial && !err_empty && !overflow, "R1 flags",
              {59'd0, busy, done, err_dial, err_empty, overflow}, 64'd0);

        // R8 transfer with A empty
        load_b(48'h1234_5678_9ABC);
        xfer(5, 1'b0, "R8 empty A");

        // R2 isolated bit at octal 43 -> position 27 -> word bit 20
        load_a(48'h0000_0010_0000);
        load_b(48'h0);
        dial(1'b0, 6'o43);
        dial(1'b1, 6'o00);
        xfer(1, 1'b0, "R2 dial decode");
        check(b_word === 48'h8000_0000_0000, "R2 bit lands at MSB", {16'd0, b_word}, 64'h8000_0000_0000);

        // R3 bad dial codes leave dials alone
        dial(1'b0, 6'o16);
        dial(1'b1, 6'o37);
        dial(1'b0, 6'o12);
        load_a(48'hA5A5_0F0F_3C3C);
        load_b(48'hFFFF_0000_FFFF);
        xfer(9, 1'b0, "R3 dials kept after reject");

        // R6 count zero
        load_a(48'hFFFF_FFFF_FFFF);
        load_b(48'h0F0F_F0F0_1234);
        xfer(0, 1'b0, "R6 zero count");

        // R4 R5 full word copy
        load_a(48'hDEAD_BEEF_CAFE);
        load_b(48'h0);
        dial(1'b0, 6'o00);
        dial(1'b1, 6'o00);
        xfer(48, 1'b0, "R4 full copy");

        // R9 overflow at destination edge
        load_a(48'hFFFF_FFFF_FFFF);
        load_b(48'h0);
        dial(1'b1, 6'o75);
        xfer(5, 1'b0, "R9 dst overflow");
        // R9 overflow at source edge, count 63
        load_a(48'h5555_5555_5555);
        load_b(48'h0);
        dial(1'b0, 6'o72);
        dial(1'b1, 6'o00);
        xfer(63, 1'b0, "R9 src overflow");

        // R10 commands poked while busy are ignored
        load_a(48'h0123_4567_89AB);
        load_b(48'hFEDC_BA98_7654);
        dial(1'b0, 6'o11);
        dial(1'b1, 6'o23);
        xfer(20, 1'b1, "R10 busy ignore");
        check(a_valid === 1'b0 && a_word === 48'h0123_4567_89AB, "R10 A untouched",
              {16'd0, a_word}, 64'h0123_4567_89AB);
        load_a(48'hF0F0_F0F0_F0F0);
        xfer(3, 1'b0, "R10 dial A untouched");

        // R5 random patterns
        for (int k = 0; k < 24; k++) begin
            logic [5:0] ca, cb;
            ca = {3'($urandom_range(0, 7)), 3'($urandom_range(0, 5))};
            cb = {3'($urandom_range(0, 7)), 3'($urandom_range(0, 5))};
            load_a({$urandom, $urandom} & 48'hFFFF_FFFF_FFFF);
            load_b({$urandom, $urandom} & 48'hFFFF_FFFF_FFFF);
            dial(1'b0, ca);
            dial(1'b1, cb);
            xfer($urandom_range(1, 30), 1'b0, "R5 random field");
        end

        repeat (2) @(negedge clk);
        check(sb_q.size() == 0, "R4 all results seen", 64'(sb_q.size()), 64'd0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule